// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block is an integer arithmetic engine whose instructions name no operands at all. Each instruction is a 3-bit opcode, plus an immediate word that only the push instruction uses. The unit keeps a last-in first-out stack in registers. A stack pointer records how many entries are occupied, so the current top sits one slot below the pointer. Binary operations take their two operands from the top two entries and leave the result on the stack in their place.

A sequencer drives the unit with code in reverse Polish order. It pushes the operands and then issues an operator, and the value of the expression ends up on top of the stack. Each instruction completes on the clock edge at which it is accepted. The top entry, the pointer and three status flags can be seen at the ports from the next cycle on.

Any instruction that cannot complete leaves the stack exactly as it was. This covers a push onto a full stack, an operator with too few entries, and a division by zero. The unit raises a flag for the fault instead.

Top module: `zstk_unit`

## Requirements
- R1: After reset the stack pointer is 0, the top output reads 0 and all three flags are low.
- R2: A valid instruction with opcode 1 (push) writes the immediate word above the current top and raises the pointer by one, so the top output shows that word.
- R3: Opcode 2 (pop) discards the top entry and lowers the pointer by one, and the entry below it becomes the top.
- R4: Opcodes 3 (add), 4 (subtract) and 5 (multiply) remove the top two entries and push one result, so the pointer drops by one. The result is computed modulo 2^DATA_W, with the entry below the top as the left operand and the top as the right operand.
- R5: Opcode 6 (divide) pushes the unsigned quotient of the second entry divided by the top entry, truncated, in place of both, and the pointer drops by one.
- R6: A push while the pointer equals DEPTH sets the overflow flag and changes neither the pointer nor any entry.
- R7: A pop on an empty stack, or an arithmetic opcode with fewer than two entries, sets the underflow flag and leaves the stack unchanged.
- R8: A divide whose top entry is zero, with at least two entries present, sets the divide-by-zero flag and leaves the stack unchanged.
- R9: Each flag gives the outcome of the most recent valid instruction. An instruction that succeeds clears all three flags. The flags hold their value while the valid input is low, and at most one flag is high at any time.
- R10: The stack and the pointer do not change while the valid input is low, nor for the opcodes 0 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Instruction strobe; opCode and immData are taken on the edge where it is high |
| opCode | input | 3 | 0 none, 1 push, 2 pop, 3 add, 4 sub, 5 mul, 6 div, 7 none |
| immData | input | DATA_W | Immediate word for push |
| topData | output | DATA_W | Current top entry, 0 when the stack is empty |
| stackPtr | output | PTR_W | Number of occupied entries |
| ovfFlag | output | 1 | Last instruction pushed onto a full stack |
| udfFlag | output | 1 | Last instruction lacked operands |
| divZeroFlag | output | 1 | Last instruction divided by zero |

## Verification
The bench evaluates reverse Polish expressions and compares every step with its own stack model. Subtract and divide use operands in unequal order, so a design that swapped left and right would return the wrong difference or quotient. The stack is filled to DEPTH and then pushed once more, which catches an off-by-one full test that either drops the extra word or overwrites the bottom slot. It also checks underflow with one entry present and a divide by zero, where a design that still moved the pointer would lose operands. Idle cycles follow each fault to show the flags are held, and a successful instruction afterwards shows they are cleared.

// File: rtl/zstk_pkg.sv
package zstk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_MUL  = 3'd5,
    OP_DIV  = 3'd6,
    OP_RSVD = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2,
    ALU_DIV = 2'd3
  } aluSel_e;

  // Strobes from control to datapath; at most one of the do* bits is high.
  typedef struct packed {
    logic    doPush;
    logic    doPop;
    logic    doReduce;
    aluSel_e aluSel;
  } stackCmd_t;

endpackage

// File: rtl/zstk_alu.sv
module zstk_alu
  import zstk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluSel_e             aluSel,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  output logic [DATA_W-1:0]   result
);

  logic [DATA_W-1:0] quot;

  // The guard keeps the divider defined; control never commits a zero divisor.
  assign quot = (rhs == '0) ? '0 : (lhs / rhs);

  always_comb begin
    unique case (aluSel)
      ALU_ADD: result = lhs + rhs;
      ALU_SUB: result = lhs - rhs;
      ALU_MUL: result = lhs * rhs;
      ALU_DIV: result = quot;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/zstk_dpath.sv
module zstk_dpath
  import zstk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCmd_t         cmd,
  input  logic [DATA_W-1:0] immData,
  output logic [PTR_W-1:0]  stackPtr,
  output logic [DATA_W-1:0] topVal
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_TWO = PTR_W'(2);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH);

  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [DATA_W-1:0] secondVal;
  logic [DATA_W-1:0] aluOut;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  secIdx;

  assign topIdx    = IDX_W'(stackPtr - PTR_ONE);
  assign secIdx    = IDX_W'(stackPtr - PTR_TWO);
  assign topVal    = (stackPtr == '0) ? '0 : slotQ[topIdx];
  assign secondVal = (stackPtr < PTR_TWO) ? '0 : slotQ[secIdx];

  zstk_alu #(.DATA_W(DATA_W)) alu_i (
    .aluSel (cmd.aluSel),
    .lhs    (secondVal),
    .rhs    (topVal),
    .result (aluOut)
  );

  // Each slot has its own write enable: a push lands where the pointer points,
  // a reduction lands two below it (the old second entry).
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [PTR_W-1:0] PUSH_AT   = PTR_W'(i);
    localparam logic [PTR_W-1:0] REDUCE_AT = PTR_W'(i + 2);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (cmd.doPush && stackPtr == PUSH_AT) begin
        q <= immData;
      end else if (cmd.doReduce && stackPtr == REDUCE_AT) begin
        q <= aluOut;
      end
    end
    assign slotQ[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= '0;
    end else if (cmd.doPush) begin
      stackPtr <= stackPtr + PTR_ONE;
    end else if (cmd.doPop || cmd.doReduce) begin
      stackPtr <= stackPtr - PTR_ONE;
    end
  end

  // R2: a committed push shows the immediate word on top one cycle later.
  a_r2_push_lands: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.doPush) |-> (topVal == $past(immData)));

  // R4: a committed reduction shrinks the stack by one entry.
  a_r4_reduce_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.doReduce) |-> (stackPtr == $past(stackPtr) - PTR_ONE));

  // R6: the pointer never passes the capacity.
  a_r6_ptr_bounded: assert property (@(posedge clk) disable iff (!rstN)
    stackPtr <= PTR_MAX);

endmodule

// File: rtl/zstk_ctrl.sv
module zstk_ctrl
  import zstk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [PTR_W-1:0]  stackPtr,
  input  logic [DATA_W-1:0] topVal,
  output stackCmd_t         cmd,
  output logic              ovfFlag,
  output logic              udfFlag,
  output logic              divZeroFlag
);

  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_TWO = PTR_W'(2);

  opcode_e op;
  logic    isPush, isPop, isBinary, isDiv;
  logic    ovfNow, udfNow, dzNow;

  assign op       = opcode_e'(opCode);
  assign isPush   = (op == OP_PUSH);
  assign isPop    = (op == OP_POP);
  assign isDiv    = (op == OP_DIV);
  assign isBinary = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || isDiv;

  // Fault detection: capacity first, then operand count, then divisor.
  assign ovfNow = opValid && isPush && (stackPtr == PTR_MAX);
  assign udfNow = opValid && ((isPop && stackPtr < PTR_ONE) ||
                              (isBinary && stackPtr < PTR_TWO));
  assign dzNow  = opValid && isDiv && !udfNow && (topVal == '0);

  always_comb begin
    cmd          = '0;
    cmd.doPush   = opValid && isPush && !ovfNow;
    cmd.doPop    = opValid && isPop && !udfNow;
    cmd.doReduce = opValid && isBinary && !udfNow && !dzNow;
    unique case (op)
      OP_SUB:  cmd.aluSel = ALU_SUB;
      OP_MUL:  cmd.aluSel = ALU_MUL;
      OP_DIV:  cmd.aluSel = ALU_DIV;
      default: cmd.aluSel = ALU_ADD;
    endcase
  end

  // Flags describe the last accepted instruction and hold while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag     <= 1'b0;
      udfFlag     <= 1'b0;
      divZeroFlag <= 1'b0;
    end else if (opValid) begin
      ovfFlag     <= ovfNow;
      udfFlag     <= udfNow;
      divZeroFlag <= dzNow;
    end
  end

  // R6: overflow leaves the pointer where it was.
  a_r6_ovf_freezes: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> $stable(stackPtr));

  // R7: underflow leaves the pointer where it was.
  a_r7_udf_freezes: assert property (@(posedge clk) disable iff (!rstN)
    udfFlag |-> $stable(stackPtr));

  // R8: divide by zero keeps both operands in place.
  a_r8_dz_freezes: assert property (@(posedge clk) disable iff (!rstN)
    divZeroFlag |-> ($stable(stackPtr) && $stable(topVal)));

  // R9: faults are mutually exclusive.
  a_r9_one_fault: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovfFlag, udfFlag, divZeroFlag}));

  // R9: flags hold across idle cycles.
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(opValid) |-> ($stable(ovfFlag) && $stable(udfFlag) && $stable(divZeroFlag)));

  // R10: an idle cycle leaves the stack untouched.
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(opValid) |-> ($stable(stackPtr) && $stable(topVal)));

  // R3: an allowed pop lowers the pointer by one.
  a_r3_pop_lowers: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode == OP_POP && stackPtr != '0) |->
      (stackPtr == $past(stackPtr) - PTR_ONE));

endmodule

// File: rtl/zstk_unit.sv
module zstk_unit
  import zstk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] immData,
  output logic [DATA_W-1:0] topData,
  output logic [PTR_W-1:0]  stackPtr,
  output logic              ovfFlag,
  output logic              udfFlag,
  output logic              divZeroFlag
);

  stackCmd_t         cmd;
  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] topQ;

  zstk_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opCode      (opCode),
    .stackPtr    (ptrQ),
    .topVal      (topQ),
    .cmd         (cmd),
    .ovfFlag     (ovfFlag),
    .udfFlag     (udfFlag),
    .divZeroFlag (divZeroFlag)
  );

  zstk_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .immData  (immData),
    .stackPtr (ptrQ),
    .topVal   (topQ)
  );

  assign stackPtr = ptrQ;
  assign topData  = topQ;

endmodule

// File: tb/zstk_unit_tb_top.sv
module zstk_unit_tb_top;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int PTR_W  = $clog2(DEPTH + 2);

  localparam logic [2:0] C_NOP = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2, C_ADD = 3'd3,
                         C_SUB = 3'd4, C_MUL = 3'd5, C_DIV = 3'd6, C_RSVD = 3'd7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [2:0]        opCode = '0;
  logic [DATA_W-1:0] immData = '0;
  logic [DATA_W-1:0] topData;
  logic [PTR_W-1:0]  stackPtr;
  logic              ovfFlag, udfFlag, divZeroFlag;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  // Reference model
  logic [DATA_W-1:0] mStk [DEPTH];
  int  mSp = 0;
  bit  mOvf = 0, mUdf = 0, mDz = 0;

  always #5 clk = ~clk;

  zstk_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .immData(immData),
    .topData(topData), .stackPtr(stackPtr), .ovfFlag(ovfFlag), .udfFlag(udfFlag),
    .divZeroFlag(divZeroFlag)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mTop();
    return (mSp == 0) ? '0 : mStk[mSp-1];
  endfunction

  task automatic modelApply(input logic [2:0] op, input logic [DATA_W-1:0] imm);
    logic [DATA_W-1:0] l, r, res;
    mOvf = 0; mUdf = 0; mDz = 0;
    case (op)
      C_PUSH: if (mSp == DEPTH) mOvf = 1; else begin mStk[mSp] = imm; mSp++; end
      C_POP:  if (mSp == 0) mUdf = 1; else mSp--;
      C_ADD, C_SUB, C_MUL, C_DIV: begin
        if (mSp < 2) mUdf = 1;
        else begin
          l = mStk[mSp-2]; r = mStk[mSp-1];
          if (op == C_DIV && r == 0) mDz = 1;
          else begin
            case (op)
              C_ADD:   res = l + r;
              C_SUB:   res = l - r;
              C_MUL:   res = l * r;
              default: res = l / r;
            endcase
            mStk[mSp-2] = res;
            mSp--;
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic compareAll(input string req);
    check(req, "stackPtr", stackPtr, mSp);
    check(req, "topData", topData, mTop());
    check(req, "ovfFlag", ovfFlag, mOvf);
    check(req, "udfFlag", udfFlag, mUdf);
    check(req, "divZeroFlag", divZeroFlag, mDz);
  endtask

  // One instruction (or one idle cycle when vld is 0), then compare with the model.
  task automatic step(input logic [2:0] op, input logic [DATA_W-1:0] imm, input bit vld,
                      input string req);
    @(negedge clk);
    opValid = vld; opCode = op; immData = imm;
    @(negedge clk);
    opValid = 1'b0;
    if (vld) modelApply(op, imm);
    compareAll(req);
  endtask

  task automatic drain();
    while (mSp > 0) step(C_POP, '0, 1, "R3");
  endtask

  task automatic t_reset();
    check("R1", "stackPtr", stackPtr, 0);
    check("R1", "topData", topData, 0);
    check("R1", "flags", {ovfFlag, udfFlag, divZeroFlag}, 0);
  endtask

  task automatic t_push_pop();
    step(C_PUSH, 32'hDEAD_BEEF, 1, "R2");
    step(C_PUSH, 32'h0000_0011, 1, "R2");
    step(C_PUSH, 32'hFFFF_FFFF, 1, "R2");
    step(C_POP, '0, 1, "R3");
    check("R3", "top after pop", topData, 32'h11);
    step(C_POP, '0, 1, "R3");
    step(C_POP, '0, 1, "R3");
    check("R3", "empty after pops", stackPtr, 0);
  endtask

  task automatic t_arith_order();
    step(C_PUSH, 32'd3, 1, "R4");
    step(C_PUSH, 32'd5, 1, "R4");
    step(C_SUB, '0, 1, "R4");
    check("R4", "3-5 wraps", topData, 32'hFFFF_FFFE);
    step(C_PUSH, 32'h0001_0000, 1, "R4");
    step(C_PUSH, 32'h0001_0000, 1, "R4");
    step(C_MUL, '0, 1, "R4");
    check("R4", "mul wraps to 0", topData, 0);
    step(C_ADD, '0, 1, "R4");
    check("R4", "add", topData, 32'hFFFF_FFFE);
    step(C_PUSH, 32'd7, 1, "R5");
    step(C_PUSH, 32'd2, 1, "R5");
    step(C_DIV, '0, 1, "R5");
    check("R5", "7/2", topData, 3);
    step(C_DIV, '0, 1, "R5");
    drain();
  endtask

  task automatic t_rpn();
    // (50 + 22) / (10 - 4) = 12
    step(C_PUSH, 32'd50, 1, "R4");
    step(C_PUSH, 32'd22, 1, "R4");
    step(C_ADD, '0, 1, "R4");
    step(C_PUSH, 32'd10, 1, "R4");
    step(C_PUSH, 32'd4, 1, "R4");
    step(C_SUB, '0, 1, "R4");
    step(C_DIV, '0, 1, "R5");
    check("R5", "rpn result", topData, 12);
    // 2 3 4 * + 5 -  =  9
    step(C_PUSH, 32'd2, 1, "R4");
    step(C_PUSH, 32'd3, 1, "R4");
    step(C_PUSH, 32'd4, 1, "R4");
    step(C_MUL, '0, 1, "R4");
    step(C_ADD, '0, 1, "R4");
    step(C_PUSH, 32'd5, 1, "R4");
    step(C_SUB, '0, 1, "R4");
    check("R4", "second rpn", topData, 9);
    drain();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) step(C_PUSH, DATA_W'(100 + i), 1, "R2");
    step(C_PUSH, 32'hBAD0_0000, 1, "R6");
    check("R6", "ovf set", ovfFlag, 1);
    check("R6", "top kept", topData, 100 + DEPTH - 1);
    step(C_NOP, '0, 0, "R9");
    check("R9", "ovf held while idle", ovfFlag, 1);
    step(C_POP, '0, 1, "R9");
    check("R9", "ovf cleared", ovfFlag, 0);
    drain();
    check("R6", "bottom slot intact", mStk[0], 100);
  endtask

  task automatic t_underflow();
    step(C_POP, '0, 1, "R7");
    check("R7", "udf on empty pop", udfFlag, 1);
    step(C_PUSH, 32'd9, 1, "R7");
    step(C_ADD, '0, 1, "R7");
    check("R7", "udf one entry", udfFlag, 1);
    check("R7", "entry kept", topData, 9);
    step(C_DIV, '0, 1, "R7");
    check("R7", "udf beats dz", {udfFlag, divZeroFlag}, 2'b10);
    drain();
  endtask

  task automatic t_divzero();
    step(C_PUSH, 32'd42, 1, "R8");
    step(C_PUSH, 32'd0, 1, "R8");
    step(C_DIV, '0, 1, "R8");
    check("R8", "dz set", divZeroFlag, 1);
    check("R8", "ptr kept", stackPtr, 2);
    step(C_POP, '0, 1, "R8");
    check("R8", "left operand kept", topData, 42);
    drain();
  endtask

  task automatic t_idle();
    step(C_PUSH, 32'h1234, 1, "R10");
    step(C_PUSH, 32'h5678, 0, "R10");
    step(C_POP, '0, 0, "R10");
    step(C_NOP, 32'h9999, 1, "R10");
    step(C_RSVD, 32'h9999, 1, "R10");
    check("R10", "top unchanged", topData, 32'h1234);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_arith_order();
    t_rpn();
    t_overflow();
    t_underflow();
    t_divzero();
    t_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule